// File: doc/BRIEF.md
# Acknowledge-Polling Command Sequencer for Serial EEPROM Access

This controller sits on top of a byte-level I2C master engine. It issues each EEPROM command once the target has finished its internal programming cycle, and it never waits out a fixed worst-case write time. While the target is programming, it ignores its own select byte. The sequencer probes it with a start condition and a write-direction select byte, and repeats that probe as long as the target stays silent.

The first probe the target acknowledges is kept as the opening byte of the pending command, so that byte is never sent twice. A write then carries on with the two memory address bytes and the data byte. A random read sends the memory address, issues a repeated start and a read-direction select byte, then fetches the requested number of bytes. A poll-only command closes the bus at once and reports that the target is ready.

Two conditions end a command early. If the number of silent probes reaches a programmable limit, the command ends with a timeout. If the target refuses any byte after its select byte, the command ends with a refusal error. Both cases close the bus with a stop condition.

Top module: `apoll_seq`

## Requirements
- R1: Each polling attempt is one START request followed by one WRITE request carrying `{cmd_dev, 1'b0}`.
- R2: A select byte that is not acknowledged is followed directly by a new START request, with no STOP in between.
- R3: If `cfg_max_tries` consecutive attempts go unacknowledged, exactly that many attempts are made. The sequencer then issues STOP and pulses `done` with `err_timeout`=1 and `err_nack`=0. A limit of 0 behaves as 1.
- R4: For `cmd_kind`=0 (write), an acknowledged select is followed by WRITE of address bits 15:8, WRITE of address bits 7:0, WRITE of `cmd_wdata`, then STOP and `done`. The select byte is not sent again.
- R5: For `cmd_kind`=1 (read), an acknowledged select is followed by the address high byte, the address low byte, RESTART, WRITE `{cmd_dev, 1'b1}`, and `cmd_rd_len` READ requests. Every READ except the last has `eng_mack`=1, and the last has `eng_mack`=0. STOP follows. Each received byte appears once on `rd_data` with a one-cycle `rd_valid`.
- R6: For `cmd_kind`=2 (poll only), an acknowledged select is followed by STOP and a `done` pulse with both error flags low.
- R7: A refused address byte, data byte or read-direction select byte leads straight to STOP. The command then ends with `err_nack`=1 and `err_timeout`=0, and no further polling takes place.
- R8: At most one engine request is outstanding. `eng_req` is a one-cycle pulse, and the next pulse comes only after `eng_done`. The `eng_op` codes are 0 START, 1 RESTART, 2 STOP, 3 WRITE and 4 READ.
- R9: `cmd_go` is taken only while `busy` is low. `busy` rises on the cycle after acceptance and stays high until the closing STOP completes. A `cmd_go` pulse while busy changes neither the running sequence nor the later behaviour.
- R10: After reset, `busy`, `done`, `err_timeout`, `err_nack`, `rd_valid` and `eng_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | Command request pulse |
| cmd_kind | input | 2 | 0 write, 1 random read, 2 poll only |
| cmd_dev | input | 7 | Target device address |
| cmd_mem_addr | input | 16 | Memory address in the target |
| cmd_wdata | input | 8 | Data byte for a write |
| cmd_rd_len | input | LEN_W | Number of bytes to read |
| cfg_max_tries | input | TRY_W | Maximum number of polling attempts |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err_timeout | output | 1 | Last command ran out of attempts |
| err_nack | output | 1 | Last command was refused after the select byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| eng_req | output | 1 | Request to the byte engine |
| eng_op | output | 3 | Engine primitive code |
| eng_wdata | output | 8 | Byte to send |
| eng_mack | output | 1 | Master acknowledge for a READ |
| eng_done | input | 1 | Engine finished the request |
| eng_sack | input | 1 | Target acknowledged the sent byte |
| eng_rdata | input | 8 | Byte received by the engine |

## Verification
The bench stands in for the byte engine and for a target that stays silent for a chosen number of probes after every stored write. From these it forms the exact primitive stream each command should produce.

It checks four kinds of fault in particular.
- Resending the select byte after the acknowledge would show up as an extra WRITE.
- Inserting a STOP between probes, or miscounting the attempt limit by one, would show up as a wrong stream or wrong error flags. The limit is tested at values 1 and 4.
- Getting the master acknowledge wrong on the final read byte would show up as a wrong `eng_mack`. This is tested with one-byte and three-byte reads.
- Restarting the poll after a refused address or data byte would show up as an unexpected START.

A `cmd_go` pulse injected mid-command must leave the stream untouched.

// File: rtl/apoll_pkg.sv
package apoll_pkg;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_RESTART = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4
  } eng_op_e;

  typedef enum logic [1:0] {
    KIND_WRITE = 2'd0,
    KIND_READ  = 2'd1,
    KIND_POLL  = 2'd2,
    KIND_RSVD  = 2'd3
  } cmd_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RST,
    ST_RSEL,
    ST_RD,
    ST_STOP
  } seq_st_e;

endpackage

// File: rtl/apoll_tries.sv
// Attempt counter: flags the attempt that reaches the programmed limit.
module apoll_tries #(
  parameter int TRY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [TRY_W-1:0] limit,
  output logic             last
);
  logic [TRY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [TRY_W:0]   cnt_plus;

  assign cnt_plus = {1'b0, cnt_q} + {{TRY_W{1'b0}}, 1'b1};
  // limit of zero compares as one
  assign last     = cnt_plus >= {1'b0, limit};

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_plus[TRY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/apoll_rdcnt.sv
// Remaining read byte counter.
module apoll_rdcnt #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             dec,
  output logic             last
);
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             rem_en;

  assign last = rem_q <= {{(LEN_W-1){1'b0}}, 1'b1};

  always_comb begin
    rem_en = load | dec;
    rem_d  = load ? len : rem_q - {{(LEN_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end
endmodule

// File: rtl/apoll_seq.sv
module apoll_seq
  import apoll_pkg::*;
#(
  parameter  int DATA_W  = 8,
  parameter  int TRY_W   = 8,
  parameter  int LEN_W   = 4,
  localparam int DEV_W   = DATA_W - 1,
  localparam int MADDR_W = 2 * DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_go,
  input  logic [1:0]         cmd_kind,
  input  logic [DEV_W-1:0]   cmd_dev,
  input  logic [MADDR_W-1:0] cmd_mem_addr,
  input  logic [DATA_W-1:0]  cmd_wdata,
  input  logic [LEN_W-1:0]   cmd_rd_len,
  input  logic [TRY_W-1:0]   cfg_max_tries,
  output logic               busy,
  output logic               done,
  output logic               err_timeout,
  output logic               err_nack,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic               eng_req,
  output logic [2:0]         eng_op,
  output logic [DATA_W-1:0]  eng_wdata,
  output logic               eng_mack,
  input  logic               eng_done,
  input  logic               eng_sack,
  input  logic [DATA_W-1:0]  eng_rdata
);
  seq_st_e            st_q, st_d;
  logic               wait_q, wait_d;
  cmd_kind_e          kind_q;
  logic [DEV_W-1:0]   dev_q;
  logic [MADDR_W-1:0] maddr_q;
  logic [DATA_W-1:0]  wdat_q;
  logic               to_q, nk_q, done_q, rdv_q;
  logic [DATA_W-1:0]  rdd_q;

  logic    accept, step;
  logic    try_clr, try_inc, try_last;
  logic    len_load, len_dec, rd_last;
  logic    set_to, set_nk;
  eng_op_e op_c;

  apoll_tries #(.TRY_W(TRY_W)) u_tries (
    .clk(clk), .rst_n(rst_n), .clr(try_clr), .inc(try_inc),
    .limit(cfg_max_tries), .last(try_last)
  );

  apoll_rdcnt #(.LEN_W(LEN_W)) u_rdcnt (
    .clk(clk), .rst_n(rst_n), .load(len_load), .len(cmd_rd_len),
    .dec(len_dec), .last(rd_last)
  );

  assign accept  = (st_q == ST_IDLE) && cmd_go;
  assign step    = wait_q && eng_done;
  assign eng_req = (st_q != ST_IDLE) && !wait_q;

  // primitive and byte presented for the current step
  always_comb begin
    op_c      = OP_STOP;
    eng_wdata = '0;
    unique case (st_q)
      ST_START: op_c = OP_START;
      ST_SEL:   begin op_c = OP_WRITE; eng_wdata = {dev_q, 1'b0}; end
      ST_AHI:   begin op_c = OP_WRITE; eng_wdata = maddr_q[MADDR_W-1:DATA_W]; end
      ST_ALO:   begin op_c = OP_WRITE; eng_wdata = maddr_q[DATA_W-1:0]; end
      ST_WDAT:  begin op_c = OP_WRITE; eng_wdata = wdat_q; end
      ST_RST:   op_c = OP_RESTART;
      ST_RSEL:  begin op_c = OP_WRITE; eng_wdata = {dev_q, 1'b1}; end
      ST_RD:    op_c = OP_READ;
      default:  op_c = OP_STOP;
    endcase
  end
  assign eng_op   = op_c;
  assign eng_mack = !rd_last;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    wait_d   = wait_q;
    try_clr  = 1'b0;
    try_inc  = 1'b0;
    len_load = 1'b0;
    len_dec  = 1'b0;
    set_to   = 1'b0;
    set_nk   = 1'b0;
    if (accept) begin
      st_d     = ST_START;
      try_clr  = 1'b1;
      len_load = 1'b1;
    end
    if (eng_req)   wait_d = 1'b1;
    else if (step) wait_d = 1'b0;
    if (step) begin
      unique case (st_q)
        ST_START: st_d = ST_SEL;
        ST_SEL: begin
          if (eng_sack)
            st_d = (kind_q == KIND_WRITE || kind_q == KIND_READ) ? ST_AHI : ST_STOP;
          else if (try_last) begin
            set_to = 1'b1;
            st_d   = ST_STOP;
          end else begin
            try_inc = 1'b1;
            st_d    = ST_START;
          end
        end
        ST_AHI: begin
          st_d   = eng_sack ? ST_ALO : ST_STOP;
          set_nk = !eng_sack;
        end
        ST_ALO: begin
          st_d   = !eng_sack ? ST_STOP : (kind_q == KIND_READ ? ST_RST : ST_WDAT);
          set_nk = !eng_sack;
        end
        ST_WDAT: begin
          st_d   = ST_STOP;
          set_nk = !eng_sack;
        end
        ST_RST: st_d = ST_RSEL;
        ST_RSEL: begin
          st_d   = eng_sack ? ST_RD : ST_STOP;
          set_nk = !eng_sack;
        end
        ST_RD: begin
          if (rd_last) st_d = ST_STOP;
          else         len_dec = 1'b1;
        end
        ST_STOP: st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wait_q  <= 1'b0;
      kind_q  <= KIND_POLL;
      dev_q   <= '0;
      maddr_q <= '0;
      wdat_q  <= '0;
      to_q    <= 1'b0;
      nk_q    <= 1'b0;
      done_q  <= 1'b0;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
    end else begin
      st_q   <= st_d;
      wait_q <= wait_d;
      if (accept) begin
        kind_q  <= cmd_kind_e'(cmd_kind);
        dev_q   <= cmd_dev;
        maddr_q <= cmd_mem_addr;
        wdat_q  <= cmd_wdata;
        to_q    <= 1'b0;
        nk_q    <= 1'b0;
      end else begin
        if (set_to) to_q <= 1'b1;
        if (set_nk) nk_q <= 1'b1;
      end
      done_q <= step && (st_q == ST_STOP);
      rdv_q  <= step && (st_q == ST_RD);
      if (step && (st_q == ST_RD)) rdd_q <= eng_rdata;
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign err_timeout = to_q;
  assign err_nack    = nk_q;
  assign rd_valid    = rdv_q;
  assign rd_data     = rdd_q;

endmodule

// File: rtl/apoll_seq_chk.sv
module apoll_seq_chk
  import apoll_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err_timeout,
  input logic              err_nack,
  input logic              rd_valid,
  input logic              eng_req,
  input logic [2:0]        eng_op,
  input logic [DATA_W-1:0] eng_wdata,
  input logic              eng_done
);
  logic [2:0] last_op_q;
  logic       pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op_q <= OP_STOP;
      pend_q    <= 1'b0;
    end else begin
      if (eng_req) last_op_q <= eng_op;
      if (eng_req)       pend_q <= 1'b1;
      else if (eng_done) pend_q <= 1'b0;
    end
  end

  // R8: request pulses, never while one is outstanding
  a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req);
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> !pend_q);
  // R1: START is followed by the write-direction select byte
  a_r1_select_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && last_op_q == OP_START) |-> (eng_op == OP_WRITE && !eng_wdata[0]));
  // R5: RESTART is followed by the read-direction select byte
  a_r5_read_select: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && last_op_q == OP_RESTART) |-> (eng_op == OP_WRITE && eng_wdata[0]));
  // R5: read strobes only after a READ primitive
  a_r5_rd_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> last_op_q == OP_READ);
  // R9: a command opens with START
  a_r9_opens_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (eng_req && eng_op == OP_START));
  // R3: completion only after the closing STOP
  a_r3_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (last_op_q == OP_STOP && !busy));
  // R7: the two error kinds exclude each other
  a_r7_single_error: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(err_timeout && err_nack));

endmodule

bind apoll_seq apoll_seq_chk #(.DATA_W(DATA_W)) u_apoll_chk (.*);

// File: tb/apoll_seq_tb_top.sv
`timescale 1ns/1ps
module apoll_seq_tb_top;
  import apoll_pkg::*;

  localparam int DW = 8;
  localparam int TW = 8;
  localparam int LW = 4;
  localparam logic [6:0] DEV = 7'h50;
  localparam logic [7:0] SEL_W = {DEV, 1'b0};
  localparam logic [7:0] SEL_R = {DEV, 1'b1};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cmd_go = 1'b0;
  logic [1:0]    cmd_kind = '0;
  logic [6:0]    cmd_dev = DEV;
  logic [15:0]   cmd_mem_addr = '0;
  logic [7:0]    cmd_wdata = '0;
  logic [LW-1:0] cmd_rd_len = '0;
  logic [TW-1:0] cfg_max_tries = 8'd8;
  logic          busy, done, err_timeout, err_nack, rd_valid;
  logic [7:0]    rd_data;
  logic          eng_req, eng_mack;
  logic [2:0]    eng_op;
  logic [7:0]    eng_wdata;
  logic          eng_done = 1'b0;
  logic          eng_sack = 1'b0;
  logic [7:0]    eng_rdata = '0;

  apoll_seq #(.DATA_W(DW), .TRY_W(TW), .LEN_W(LW)) dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string cur_req = "R1";

  int         exp_op[$];
  logic [7:0] exp_dat[$];
  logic [7:0] rd_seen[$];

  // behavioural target
  int          busy_left = 0;
  int          busy_cfg = 3;
  int          sel_nacks = 0;
  int          phase = 0;
  logic [15:0] m_addr = '0;
  bit          wrote = 0;
  bit          nack_ahi = 0;
  bit          nack_dat = 0;
  logic [7:0]  mem [logic [15:0]];

  bit          pend = 0;
  int          cnt = 0;
  logic        resp_ack = 1'b0;
  logic [7:0]  resp_dat = '0;

  bit done_seen = 0;
  bit seen_to = 0;
  bit seen_nk = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pe(int op, logic [7:0] d);
    exp_op.push_back(op);
    exp_dat.push_back(d);
  endtask

  task automatic attempts(int n);
    for (int i = 0; i < n; i++) begin
      pe(0, 8'h00);
      pe(3, SEL_W);
    end
  endtask

  task automatic model_op();
    int op;
    int eo;
    logic [7:0] ed;
    op = int'(eng_op);
    if (exp_op.size() == 0) begin
      check(0, "R8", "unexpected engine op", op, -1);
    end else begin
      eo = exp_op.pop_front();
      ed = exp_dat.pop_front();
      check(op == eo, cur_req, "engine op", op, eo);
      if (op == 3) check(eng_wdata == ed, cur_req, "sent byte", int'(eng_wdata), int'(ed));
      if (op == 4) check(eng_mack == ed[0], "R5", "master ack", int'(eng_mack), int'(ed[0]));
    end
    resp_ack = 1'b0;
    case (op)
      0, 1: phase = 0;
      2: begin
        if (wrote) busy_left = busy_cfg;
        wrote = 0;
        phase = 0;
      end
      3: begin
        case (phase)
          0: begin
            if (eng_wdata[7:1] != DEV) resp_ack = 1'b0;
            else if (busy_left > 0) begin
              resp_ack = 1'b0;
              busy_left--;
              sel_nacks++;
            end else begin
              resp_ack = 1'b1;
              phase = eng_wdata[0] ? 4 : 1;
            end
          end
          1: begin resp_ack = !nack_ahi; m_addr[15:8] = eng_wdata; phase = 2; end
          2: begin resp_ack = 1'b1; m_addr[7:0] = eng_wdata; phase = 3; end
          3: begin
            resp_ack = !nack_dat;
            if (!nack_dat) begin
              mem[m_addr] = eng_wdata;
              wrote = 1;
            end
            m_addr++;
          end
          default: resp_ack = 1'b0;
        endcase
      end
      4: begin
        resp_dat = mem.exists(m_addr) ? mem[m_addr] : 8'hFF;
        m_addr++;
        resp_ack = 1'b1;
      end
      default: resp_ack = 1'b0;
    endcase
  endtask

  // byte engine model: completes each request two cycles after it is seen
  always @(negedge clk) begin
    eng_done = 1'b0;
    if (pend) begin
      cnt--;
      if (cnt == 0) begin
        eng_done  = 1'b1;
        eng_sack  = resp_ack;
        eng_rdata = resp_dat;
        pend = 0;
      end
    end else if (rst_n && eng_req) begin
      model_op();
      pend = 1;
      cnt = 2;
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        done_seen = 1;
        seen_to = err_timeout;
        seen_nk = err_nack;
      end
      if (rd_valid) rd_seen.push_back(rd_data);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog: actual=%0d expected=<%0d cycles", cyc, cyc);
      summary();
      $finish;
    end
  end

  task automatic run_cmd(int kind, logic [15:0] addr, logic [7:0] wd, int len,
                         int maxt, bit exp_to, bit exp_nk, string req, bit poke);
    done_seen = 0;
    rd_seen.delete();
    cur_req = req;
    @(negedge clk);
    cmd_kind      = 2'(kind);
    cmd_mem_addr  = addr;
    cmd_wdata     = wd;
    cmd_rd_len    = LW'(len);
    cfg_max_tries = TW'(maxt);
    cmd_go        = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
    check(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      cmd_kind     = 2'd2;
      cmd_mem_addr = 16'hFFFF;
      cmd_wdata    = 8'h00;
      cmd_go       = 1'b1;
      @(negedge clk);
      cmd_go = 1'b0;
    end
    for (int i = 0; i < 3000 && !done_seen; i++) @(negedge clk);
    check(done_seen, req, "done seen", int'(done_seen), 1);
    check(seen_to == exp_to, "R3", "timeout flag", int'(seen_to), int'(exp_to));
    check(seen_nk == exp_nk, "R7", "refusal flag", int'(seen_nk), int'(exp_nk));
    check(exp_op.size() == 0, req, "primitives left", exp_op.size(), 0);
    exp_op.delete();
    exp_dat.delete();
    @(negedge clk);
    check(busy == 1'b0, "R9", "idle after done", int'(busy), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R10", "busy/done after reset", int'({busy, done}), 0);
    check(err_timeout == 1'b0 && err_nack == 1'b0, "R10", "errors after reset",
          int'({err_timeout, err_nack}), 0);
    check(eng_req == 1'b0 && rd_valid == 1'b0, "R10", "req/rd after reset",
          int'({eng_req, rd_valid}), 0);

    // R4: write to an idle target
    attempts(1); pe(3, 8'h12); pe(3, 8'h34); pe(3, 8'hA5); pe(2, 8'h00);
    run_cmd(0, 16'h1234, 8'hA5, 1, 8, 0, 0, "R4", 0);

    // R2 + R9: write while the target programs, with a stray cmd_go
    sel_nacks = 0;
    attempts(4); pe(3, 8'h12); pe(3, 8'h35); pe(3, 8'h3C); pe(2, 8'h00);
    run_cmd(0, 16'h1235, 8'h3C, 1, 8, 0, 0, "R2", 1);
    check(sel_nacks == 3, "R2", "silent probes", sel_nacks, 3);
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R9", "stray cmd_go not taken", int'(busy), 0);

    // R5: three-byte random read after polling
    attempts(4); pe(3, 8'h12); pe(3, 8'h34); pe(1, 8'h00); pe(3, SEL_R);
    pe(4, 8'h01); pe(4, 8'h01); pe(4, 8'h00); pe(2, 8'h00);
    run_cmd(1, 16'h1234, 8'h00, 3, 8, 0, 0, "R5", 0);
    check(rd_seen.size() == 3, "R5", "read strobes", rd_seen.size(), 3);
    if (rd_seen.size() == 3) begin
      check(rd_seen[0] == 8'hA5, "R5", "read byte 0", int'(rd_seen[0]), 'hA5);
      check(rd_seen[1] == 8'h3C, "R5", "read byte 1", int'(rd_seen[1]), 'h3C);
      check(rd_seen[2] == 8'hFF, "R5", "read byte 2", int'(rd_seen[2]), 'hFF);
    end

    // R5: one-byte read, single READ gets no master ack
    attempts(1); pe(3, 8'h12); pe(3, 8'h35); pe(1, 8'h00); pe(3, SEL_R);
    pe(4, 8'h00); pe(2, 8'h00);
    run_cmd(1, 16'h1235, 8'h00, 1, 8, 0, 0, "R5", 0);
    check(rd_seen.size() == 1, "R5", "single read strobe", rd_seen.size(), 1);
    if (rd_seen.size() == 1)
      check(rd_seen[0] == 8'h3C, "R5", "single read byte", int'(rd_seen[0]), 'h3C);

    // R6: poll only, idle and busy target
    attempts(1); pe(2, 8'h00);
    run_cmd(2, 16'h0000, 8'h00, 1, 8, 0, 0, "R6", 0);
    busy_left = 2;
    attempts(3); pe(2, 8'h00);
    run_cmd(2, 16'h0000, 8'h00, 1, 8, 0, 0, "R6", 0);

    // R3: attempt limit 4, then limit 1, then recovery
    busy_left = 10;
    attempts(4); pe(2, 8'h00);
    run_cmd(0, 16'h0100, 8'h11, 1, 4, 1, 0, "R3", 0);
    check(busy_left == 6, "R3", "probes before timeout", 10 - busy_left, 4);
    attempts(1); pe(2, 8'h00);
    run_cmd(2, 16'h0000, 8'h00, 1, 1, 1, 0, "R3", 0);
    attempts(6); pe(2, 8'h00);
    run_cmd(2, 16'h0000, 8'h00, 1, 8, 0, 0, "R2", 0);

    // R7: refused address byte, then refused data byte
    nack_ahi = 1;
    attempts(1); pe(3, 8'h12); pe(2, 8'h00);
    run_cmd(0, 16'h1240, 8'h77, 1, 8, 0, 1, "R7", 0);
    nack_ahi = 0;
    nack_dat = 1;
    attempts(1); pe(3, 8'h12); pe(3, 8'h41); pe(3, 8'h5A); pe(2, 8'h00);
    run_cmd(0, 16'h1241, 8'h5A, 1, 8, 0, 1, "R7", 0);
    nack_dat = 0;
    // flags cleared by the next command, target never went busy
    attempts(1); pe(2, 8'h00);
    run_cmd(2, 16'h0000, 8'h00, 1, 8, 0, 0, "R6", 0);

    repeat (20) @(negedge clk);
    check(busy == 1'b0 && eng_req == 1'b0, "R8", "quiet at end", int'({busy, eng_req}), 0);
    summary();
    $finish;
  end

endmodule